// File: doc/BRIEF.md
# Timer Prescaler With Debug Run-Control

This block is the counting core of a general-purpose timer. It contains a free-running prescaler counter, a pulse accumulator that counts rising edges on one input pin, and a two-stage input synchronizer for each pin. A rising edge on the capture pin copies the prescaler value into a capture register and raises an interrupt flag. All of this sits behind a run-control layer with three ways to halt the timer:

- **Hard stop.** A control bit freezes everything and restricts register access.
- **Debug freeze.** A freeze request from a debugger halts counting and pin sampling, and unlocks protected registers so they can be patched.
- **Single-step.** A hold bit parks the timer. A self-clearing increment bit then advances the prescaler and the synchronizers by one clock at a time.

Software reaches the block through a plain register interface: a write strobe, an address and write data, and a combinational read-data path. Addresses:

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Interrupt |
| 2 | Write-once setup |
| 3 | Prescaler |
| 4 | Accumulator |
| 5 | Capture |
| 6 | Pin view |

Control register bits: 0 = stop, 1 = freeze enable, 2 = spare (stored only), 3 = hold, 4 = step increment. The interrupt output is the capture flag gated by the interrupt enable.

Top module: `tmr_core`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: With no halt mode active, the prescaler (address 3) advances by exactly one each clock and wraps modulo 2^PRE_W.
- R3: While control bit 0 (stop) is set, the prescaler, accumulator, synchronizers and capture logic hold. Reads of any address other than 0 and 1 return 0, and writes to those addresses are ignored.
- R4: Freeze is active only while `dbg_freeze_i` is 1 and control bit 1 is 1; control bit 2 has no effect. Under freeze, the prescaler and accumulator stop and pin changes are ignored. Freeze ends when either condition drops.
- R5: Under freeze, the prescaler (3), accumulator (4) and capture (5) registers take written data. Setup (2) can be written any number of times and does not lock.
- R6: Outside freeze, the first accepted write to setup (2) locks it. Later writes are ignored until reset. Outside freeze, writes to addresses 3, 4 and 5 are ignored.
- R7: With setup bit 1 set, a rising edge on `pin_i[0]` copies the prescaler into the capture register and sets interrupt bit 1 (the flag), three clocks after the pin rises.
  - `irq_o` equals the flag ANDed with interrupt bit 0 (enable).
  - Writing 1 to interrupt bit 1 clears the flag.
- R8: With setup bit 0 set and no halt mode active, the accumulator counts each rising edge on `pin_i[1]`, wrapping modulo 2^PA_W.
- R9: While control bit 3 (hold) is set, the prescaler and accumulator stop. The pin view (address 6, bit i = pin i) returns the synchronized pin values captured when hold was set.
- R10: Writing control bits 3 and 4 together makes the prescaler advance by exactly one, one clock after the write, and clocks the synchronizers once. Bit 4 then reads back 0.
- R11: A write of control bit 4 with bit 3 clear has no effect, and bit 4 reads 0.
- R12: Stop overrides freeze and step. A pending step increment is kept while stop is set and fires one clock after stop is cleared.
- R13: A capture edge already detected by the synchronizer completes, and sets the flag, even if freeze asserts in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dbg_freeze_i | input | 1 | Debug freeze request |
| pin_i | input | NPIN | Timer input pins (0 = capture, 1 = accumulator) |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_o | output | 1 | Capture interrupt |

## Verification
The capture pipeline and the debug freeze can act in the same cycle: a pin edge sits between the synchronizer and the capture register just as freeze asserts. The bench provokes this by raising the capture pin, letting two clocks pass, and asserting the freeze request before the third edge. It then judges the result by checking that the flag is set and that the capture register holds the prescaler value from the second edge, while the prescaler itself stays frozen. A second collision arises when a step increment is pending while stop is set; the bench checks that exactly one count appears after stop is released.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] A_IRQ   = 3'd1;
  localparam logic [ADDR_W-1:0] A_SETUP = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRE   = 3'd3;
  localparam logic [ADDR_W-1:0] A_PA    = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAP   = 3'd5;
  localparam logic [ADDR_W-1:0] A_PIN   = 3'd6;

  localparam int unsigned CFG_W = 5;
  localparam int unsigned IRQ_IE = 0;
  localparam int unsigned IRQ_FLAG = 1;
  localparam int unsigned SET_PA = 0;
  localparam int unsigned SET_CAP = 1;
  localparam int unsigned SETUP_W = 2;

  // bit order matches control register layout: inc=4 hold=3 frz=2:1 stop=0
  typedef struct packed {
    logic       inc;
    logic       hold;
    logic [1:0] frz_en;
    logic       stop;
  } cfg_t;
endpackage

// File: rtl/tmr_runctl.sv
module tmr_runctl
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             dbg_freeze_i,
  output cfg_t             cfg_o,
  output logic             hold_rise_o,
  output logic             freeze_o,
  output logic             run_o,
  output logic             tick_o
);
  cfg_t cfg_q;
  cfg_t cfg_wd;
  logic fire;

  assign cfg_wd = cfg_t'(cfg_wdata_i);

  // stop > freeze > step
  assign freeze_o    = ~cfg_q.stop & dbg_freeze_i & cfg_q.frz_en[0];
  assign fire        = ~cfg_q.stop & ~freeze_o & cfg_q.hold & cfg_q.inc;
  assign run_o       = ~cfg_q.stop & ~freeze_o & ~cfg_q.hold;
  assign tick_o      = run_o | fire;
  assign hold_rise_o = cfg_wr_i & cfg_wd.hold & ~cfg_q.hold;
  assign cfg_o       = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cfg_wr_i) begin
      cfg_q.stop   <= cfg_wd.stop;
      cfg_q.frz_en <= cfg_wd.frz_en;
      cfg_q.hold   <= cfg_wd.hold;
      cfg_q.inc    <= cfg_wd.inc & cfg_wd.hold;
    end else if (fire) begin
      cfg_q.inc <= 1'b0;
    end
  end

  // R10: step increment clears itself after firing
  a_r10_inc_selfclear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !cfg_wr_i |=> !cfg_q.inc);
  // R11: increment never pending without hold
  a_r11_inc_needs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.hold |-> !cfg_q.inc);
  // R12: pending increment survives stop
  a_r12_inc_waits_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.stop && cfg_q.inc && !cfg_wr_i |=> cfg_q.inc);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (ld_i) cnt_q <= ld_val_i;
    else if (en_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // R2: single-step advance with wrap
  a_r2_adv_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !ld_i |=> cnt_o == $past(cnt_o) + W'(1));
  // R3/R4/R9: halted counter holds
  a_r3_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !ld_i |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_insync.sv
module tmr_insync #(
  parameter int unsigned NPIN = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] sync_o,
  output logic [NPIN-1:0] rise_o
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else if (en_i) begin
        s1_q <= pin_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
    // edge that the synchronizer output takes on this clock
    assign rise_o[g] = en_i & s1_q & ~s2_q;
  end

  // R4/R9: pins ignored while synchronizers are not clocked
  a_r4_sync_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sync_o));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PRE_W  = 16,
  parameter int unsigned PA_W   = 8,
  parameter int unsigned NPIN   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_freeze_i,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned CAP_PIN = 0;
  localparam int unsigned PA_PIN  = 1;

  cfg_t            cfg;
  logic            hold_rise, freeze, run, tick;
  logic            always_open, acc_ok, wr_ok;
  logic [NPIN-1:0] sync, rise, snap_q;
  logic [PRE_W-1:0] pre_cnt, cap_q;
  logic [PA_W-1:0]  pa_cnt;
  logic [SETUP_W-1:0] setup_q;
  logic            lock_q, ie_q, flag_q, cap_pend_q;
  logic            pre_ld, pa_ld, pa_inc, cap_fire;

  // stop leaves only control and interrupt registers reachable
  assign always_open = (addr_i == A_CFG) || (addr_i == A_IRQ);
  assign acc_ok      = ~cfg.stop | always_open;
  assign wr_ok       = wr_i & acc_ok;

  tmr_runctl u_runctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_wr_i    (wr_ok && addr_i == A_CFG),
    .cfg_wdata_i (wdata_i[CFG_W-1:0]),
    .dbg_freeze_i(dbg_freeze_i),
    .cfg_o       (cfg),
    .hold_rise_o (hold_rise),
    .freeze_o    (freeze),
    .run_o       (run),
    .tick_o      (tick)
  );

  tmr_insync #(.NPIN(NPIN)) u_insync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick),
    .pin_i (pin_i),
    .sync_o(sync),
    .rise_o(rise)
  );

  assign pre_ld = wr_ok && freeze && addr_i == A_PRE;
  assign pa_ld  = wr_ok && freeze && addr_i == A_PA;
  assign pa_inc = run & setup_q[SET_PA] & rise[PA_PIN];

  tmr_counter #(.W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tick),
    .ld_i    (pre_ld),
    .ld_val_i(wdata_i[PRE_W-1:0]),
    .cnt_o   (pre_cnt)
  );

  tmr_counter #(.W(PA_W)) u_pa (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (pa_inc),
    .ld_i    (pa_ld),
    .ld_val_i(wdata_i[PA_W-1:0]),
    .cnt_o   (pa_cnt)
  );

  // capture completes regardless of freeze once the edge is in flight
  assign cap_fire = cap_pend_q & setup_q[SET_CAP] & ~cfg.stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_pend_q <= 1'b0;
      cap_q      <= '0;
      flag_q     <= 1'b0;
      ie_q       <= 1'b0;
    end else begin
      if (!cfg.stop) cap_pend_q <= rise[CAP_PIN];
      if (cap_fire) cap_q <= pre_cnt;
      else if (wr_ok && freeze && addr_i == A_CAP) cap_q <= wdata_i[PRE_W-1:0];
      if (wr_ok && addr_i == A_IRQ) ie_q <= wdata_i[IRQ_IE];
      if (cap_fire) flag_q <= 1'b1;
      else if (wr_ok && addr_i == A_IRQ && wdata_i[IRQ_FLAG]) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q <= '0;
      lock_q  <= 1'b0;
    end else if (wr_ok && addr_i == A_SETUP) begin
      if (freeze) begin
        setup_q <= wdata_i[SETUP_W-1:0];
      end else if (!lock_q) begin
        setup_q <= wdata_i[SETUP_W-1:0];
        lock_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (hold_rise) snap_q <= sync;
  end

  always_comb begin
    rdata_o = '0;
    if (acc_ok) begin
      unique case (addr_i)
        A_CFG:   rdata_o[CFG_W-1:0] = cfg;
        A_IRQ:   rdata_o[1:0] = {flag_q, ie_q};
        A_SETUP: rdata_o[SETUP_W-1:0] = setup_q;
        A_PRE:   rdata_o[PRE_W-1:0] = pre_cnt;
        A_PA:    rdata_o[PA_W-1:0] = pa_cnt;
        A_CAP:   rdata_o[PRE_W-1:0] = cap_q;
        A_PIN:   rdata_o[NPIN-1:0] = cfg.hold ? snap_q : sync;
        default: rdata_o = '0;
      endcase
    end
  end

  assign irq_o = flag_q & ie_q;

  // R6: locked setup only changes under freeze
  a_r6_setup_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && !freeze |=> $stable(setup_q));
  // R13: a detected capture edge always lands
  a_r13_cap_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_pend_q && setup_q[SET_CAP] && !cfg.stop |=> flag_q && cap_q == $past(pre_cnt));
  // R3: stop freezes the capture path
  a_r3_stop_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.stop |=> $stable(cap_q) && $stable(cap_pend_q));
  // R5: outside freeze the capture register moves only on a capture
  a_r5_cap_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze && !cap_fire |=> $stable(cap_q));
endmodule

// File: tb/tmr_core_bench.sv
module tmr_core_bench;
  localparam int DW = 16;
  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          dbg = 1'b0;
  logic [1:0]    pins = '0;
  logic          wr = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_core u_tmr_core (
    .clk_i(clk), .rst_ni(rst_ni), .dbg_freeze_i(dbg), .pin_i(pins),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [15:0] adv(input logic [15:0] v, input int n);
    return v + 16'(n);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [DW-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [DW-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, p0, pa0;
    int n;
    void'($urandom(32'h5eed_1234));
    cyc(2);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state (PRE already counting once out of reset, check others)
    for (int a = 0; a < 7; a++) begin
      if (a != 3) begin rreg(3'(a), d); chk("R1", d, '0); end
    end
    chk("R1 irq", DW'(irq), '0);

    // R2 free running under random intervals
    for (int i = 0; i < 6; i++) begin
      n = int'($urandom_range(1, 40));
      rreg(3'd3, p0); cyc(n); rreg(3'd3, d);
      chk("R2", d, adv(p0, n));
    end

    // R3 stop: counting halts, other regs hidden, writes ignored
    rreg(3'd3, p0);
    wreg(3'd0, 16'h0001);
    pins = 2'b11; cyc(3); pins = 2'b00;
    rreg(3'd3, d); chk("R3 read hidden", d, '0);
    wreg(3'd2, 16'h0003);
    rreg(3'd0, d); chk("R3 cfg visible", d, 16'h0001);
    wreg(3'd0, 16'h0000);
    rreg(3'd3, d); chk("R3 halted", d, adv(p0, 1));
    rreg(3'd2, d); chk("R3 setup write ignored", d, '0);

    // R4 freeze halts prescaler and pins
    wreg(3'd0, 16'h0002);
    dbg = 1'b1;
    rreg(3'd3, p0); rreg(3'd4, pa0);
    pins = 2'b10; cyc(2); pins = 2'b00; cyc(4);
    rreg(3'd3, d); chk("R4 frozen", d, p0);
    // R5 writes under freeze
    wreg(3'd3, 16'h1234); rreg(3'd3, d); chk("R5 pre load", d, 16'h1234);
    wreg(3'd4, 16'h00f0); rreg(3'd4, d); chk("R5 pa load", d, 16'h00f0);
    wreg(3'd5, 16'hbeef); rreg(3'd5, d); chk("R5 cap load", d, 16'hbeef);
    wreg(3'd2, 16'h0002); wreg(3'd2, 16'h0001);
    rreg(3'd2, d); chk("R5 setup rewrite", d, 16'h0001);
    // R4 ends by clearing enable bit
    wreg(3'd0, 16'h0000);
    rreg(3'd3, d); chk("R4 exit", d, 16'h1234);
    cyc(3); rreg(3'd3, d); chk("R4 resumed", d, 16'h1237);
    // R4 spare bit has no effect
    wreg(3'd0, 16'h0004);
    rreg(3'd3, p0); cyc(5); rreg(3'd3, d); chk("R4 spare bit", d, adv(p0, 5));
    dbg = 1'b0;
    wreg(3'd0, 16'h0000);

    // R6 write-once outside freeze
    wreg(3'd2, 16'h0003); wreg(3'd2, 16'h0000);
    rreg(3'd2, d); chk("R6 locked", d, 16'h0003);
    rreg(3'd3, p0); wreg(3'd3, 16'h0000);
    rreg(3'd3, d); chk("R6 pre read-only", d, adv(p0, 1));

    // R7 capture and interrupt
    wreg(3'd1, 16'h0001);
    rreg(3'd3, p0); pins[0] = 1'b1;
    cyc(3);
    rreg(3'd5, d); chk("R7 cap value", d, adv(p0, 2));
    rreg(3'd1, d); chk("R7 flag", d, 16'h0003);
    chk("R7 irq", DW'(irq), 16'h1);
    pins[0] = 1'b0;
    wreg(3'd1, 16'h0003);
    rreg(3'd1, d); chk("R7 flag clear", d, 16'h0001);
    chk("R7 irq low", DW'(irq), 16'h0);

    // R8 random pulse train on accumulator pin
    rreg(3'd4, pa0);
    for (int i = 0; i < 20; i++) begin
      pins[1] = 1'b1; cyc(int'($urandom_range(1, 4)));
      pins[1] = 1'b0; cyc(int'($urandom_range(1, 4)));
    end
    cyc(4);
    rreg(3'd4, d); chk("R8 count", d, (pa0 + 16'd20) & 16'h00ff);

    // R9 hold with pin snapshot
    pins[0] = 1'b1; cyc(4);
    wreg(3'd0, 16'h0008);
    rreg(3'd3, p0);
    pins[0] = 1'b0; cyc(5);
    rreg(3'd3, d); chk("R9 held", d, p0);
    // R10 single steps
    n = int'($urandom_range(2, 6));
    for (int i = 0; i < n; i++) begin
      wreg(3'd0, 16'h0018);
      @(negedge clk);
      rreg(3'd3, d); chk("R10 step", d, adv(p0, i + 1));
      rreg(3'd0, d); chk("R10 self clear", d, 16'h0008);
    end
    rreg(3'd6, d); chk("R9 pin snapshot", d, 16'h0001);
    // R11 increment without hold
    wreg(3'd0, 16'h0010);
    rreg(3'd0, d); chk("R11 no effect", d, 16'h0000);
    rreg(3'd3, p0); cyc(3); rreg(3'd3, d); chk("R11 running", d, adv(p0, 3));

    // R12 stop over pending step
    wreg(3'd0, 16'h0008);
    rreg(3'd3, p0);
    wreg(3'd0, 16'h0019);
    cyc(4);
    rreg(3'd0, d); chk("R12 pending", d, 16'h0019);
    wreg(3'd0, 16'h0018);
    @(negedge clk);
    rreg(3'd3, d); chk("R12 fires after stop", d, adv(p0, 1));
    wreg(3'd0, 16'h0000);

    // R13 capture in flight when freeze asserts
    wreg(3'd1, 16'h0003);
    wreg(3'd0, 16'h0002);
    cyc(3);
    rreg(3'd3, p0); pins[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    dbg = 1'b1;
    @(negedge clk);
    rreg(3'd1, d); chk("R13 flag", d, 16'h0003);
    rreg(3'd5, d); chk("R13 cap", d, adv(p0, 2));
    cyc(3); rreg(3'd3, d); chk("R13 frozen", d, adv(p0, 2));
    dbg = 1'b0; pins = '0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule